// File: doc/BRIEF.md
# DMA Channel Run Control with Block Reload

This block is the control core of one DMA channel. A two-bit run command written by the processor starts, pauses or stops the channel, and a two-bit status tells software what state the channel is in. While running, the channel moves a block one element at a time. Each element is a read request on a request/acknowledge port, a read completion pulse, and then a write on a valid/ready port. Source and destination addresses step by a fixed element size.

A pause or stop does not halt the channel at once. The channel keeps reporting running until every write whose read has finished has been accepted. If read synchronization is present when the halt command arrives, one more whole element is let through first. At the end of a block the channel either falls back to stopped or, with automatic reload enabled, copies a new source, destination and count from a shadow bank and carries on. Software may fill the shadow bank at any point during the current block.

Back-pressure rules: `rd_valid` rises only when the channel launches an element, and it then holds with a stable `rd_addr` until `rd_ready` is sampled high. `wr_valid` stays high with a stable `wr_addr` while any write is pending and `wr_ready` is low. When `MAX_PEND` writes are pending, no new read is launched.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset, `status` is 00 (stopped), and `rd_valid` and `wr_valid` are both low.
- R2: A command of 01 while stopped makes `status` read 01 from the next cycle. The reads then go out to source, source+ELEM_BYTES, and so on. The writes go to destination, destination+ELEM_BYTES, and so on, in the same order.
- R3: A command of 01 while the channel is running leaves the state, the count and both address sequences unchanged.
- R4: A command of 10 (pause) keeps `status` at 01 until every pending write is accepted, then sets it to 10. With no read synchronization at the command cycle, no new read is launched after the command.
- R5: If `sync_in` is high at the pause or stop command cycle and elements remain, exactly one more complete element (read and write) is transferred before the channel halts.
- R6: A command of 00 (stop) drains like a pause and then sets `status` to 00. From paused, 00 stops at once and 01 resumes the block where it left off.
- R7: When the last element's write is accepted and reload is disabled, `status` returns to 00. Exactly the configured count of elements has then been moved.
- R8: With `autoinit_en` high, at block end the source, destination and count are copied from the shadow bank in one cycle. Transfers continue from the new addresses and `status` stays 01.
- R9: Writes to the shadow bank while a block is active do not alter that block's addresses or count.
- R10: A command of 11 is ignored in every state, and `status` never reads 11.
- R11: While `MAX_PEND` writes are pending, no read is launched, and `wr_valid` holds until `wr_ready`.
- R12: Writes to the working source, destination and count take effect only while `status` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Run-command write strobe |
| cmd_code | input | 2 | 00 stop, 01 run, 10 pause, 11 ignored |
| status | output | 2 | 00 stopped, 01 running, 10 paused |
| autoinit_en | input | 1 | Reload from shadow bank at block end |
| sync_in | input | 1 | Read synchronization present |
| cfg_wr | input | 1 | Write working source, destination and count |
| cfg_src | input | ADDR_W | Working source address |
| cfg_dst | input | ADDR_W | Working destination address |
| cfg_cnt | input | CNT_W | Working element count |
| rld_wr | input | 1 | Write shadow bank |
| rld_src | input | ADDR_W | Shadow source address |
| rld_dst | input | ADDR_W | Shadow destination address |
| rld_cnt | input | CNT_W | Shadow element count |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read address |
| rd_cpl | input | 1 | Read completion pulse |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted (acknowledge) |
| wr_addr | output | ADDR_W | Write address |

## Verification
The bench builds the block with `MAX_PEND` = 2, `CNT_W` = 8 and `ELEM_BYTES` = 4. The small pending cap means that holding `wr_ready` low stops reads after two elements. The channel can therefore be parked with a known number of writes pending, and a halt command lands at a predictable point. From there, the drain with and without the extra element gives distinct read and write totals. The four-byte step makes every logged address show directly which element it belongs to and whether a reload or restart disturbed the sequence.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;
  localparam logic [1:0] CODE_STOP  = 2'b00;
  localparam logic [1:0] CODE_RUN   = 2'b01;
  localparam logic [1:0] CODE_PAUSE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_HOLD
  } rc_state_e;
endpackage

// File: rtl/dma_rc_params.sv
module dma_rc_params #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int ELEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              rld_wr,
  input  logic [ADDR_W-1:0] rld_src,
  input  logic [ADDR_W-1:0] rld_dst,
  input  logic [CNT_W-1:0]  rld_cnt,
  input  logic              reload,
  input  logic              launch,
  input  logic              rd_fire,
  input  logic              wr_fire,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              remain_zero
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ELEM_BYTES);

  logic [ADDR_W-1:0] src_q, dst_q, sh_src_q, sh_dst_q;
  logic [CNT_W-1:0]  rem_q, sh_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_src_q <= '0;
      sh_dst_q <= '0;
      sh_cnt_q <= '0;
    end else if (rld_wr) begin
      sh_src_q <= rld_src;
      sh_dst_q <= rld_dst;
      sh_cnt_q <= rld_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (reload) begin
      src_q <= sh_src_q;
      dst_q <= sh_dst_q;
      rem_q <= sh_cnt_q;
    end else if (cfg_en) begin
      src_q <= cfg_src;
      dst_q <= cfg_dst;
      rem_q <= cfg_cnt;
    end else begin
      if (rd_fire) src_q <= src_q + STEP;
      if (wr_fire) dst_q <= dst_q + STEP;
      if (launch)  rem_q <= rem_q - 1'b1;
    end
  end

  assign rd_addr     = src_q;
  assign wr_addr     = dst_q;
  assign remain_zero = (rem_q == '0);

  // R9: a shadow write alone never moves the working registers
  assert_rld_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_wr && !reload && !cfg_en && !rd_fire && !wr_fire && !launch)
      |=> ($stable(src_q) && $stable(dst_q) && $stable(rem_q)));
endmodule

// File: rtl/dma_rc_xfer.sv
module dma_rc_xfer #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic remain_zero,
  input  logic rd_ready,
  input  logic rd_cpl,
  input  logic wr_ready,
  output logic launch,
  output logic rd_valid,
  output logic rd_fire,
  output logic wr_valid,
  output logic wr_fire,
  output logic quiet
);
  localparam int PEND_W = $clog2(MAX_PEND + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(MAX_PEND);

  logic              req_q, wait_q;
  logic [PEND_W-1:0] pend_q;
  logic              cpl_ok;

  assign launch   = rd_go && !req_q && !wait_q && !remain_zero && (pend_q < PEND_MAX);
  assign rd_valid = req_q;
  assign rd_fire  = req_q && rd_ready;
  assign wr_valid = (pend_q != '0);
  assign wr_fire  = wr_valid && wr_ready;
  assign cpl_ok   = wait_q && rd_cpl;
  assign quiet    = !req_q && !wait_q && (pend_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      pend_q <= '0;
    end else begin
      if (launch)       req_q <= 1'b1;
      else if (rd_fire) req_q <= 1'b0;
      if (rd_fire)      wait_q <= 1'b1;
      else if (cpl_ok)  wait_q <= 1'b0;
      case ({cpl_ok, wr_fire})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assert_pend_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_MAX);
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
endmodule

// File: rtl/dma_rc_fsm.sv
module dma_rc_fsm
  import dma_rc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       sync_in,
  input  logic       autoinit_en,
  input  logic       quiet,
  input  logic       remain_zero,
  input  logic       launch,
  output logic       rd_go,
  output logic       reload,
  output logic       idle,
  output logic [1:0] status
);
  rc_state_e state_q;
  logic      to_stop_q, extra_q;
  logic      run_cmd, stop_cmd, halt_cmd, blk_end, drain_done;

  assign run_cmd    = cmd_valid && (cmd_code == CODE_RUN);
  assign stop_cmd   = cmd_valid && (cmd_code == CODE_STOP);
  assign halt_cmd   = stop_cmd || (cmd_valid && (cmd_code == CODE_PAUSE));
  assign blk_end    = remain_zero && quiet;
  assign drain_done = quiet && (!extra_q || remain_zero);
  assign reload     = autoinit_en && blk_end &&
                      (((state_q == ST_RUN) && !halt_cmd) || (state_q == ST_DRAIN));
  assign rd_go      = ((state_q == ST_RUN) && !halt_cmd && sync_in) ||
                      ((state_q == ST_DRAIN) && extra_q);
  assign idle       = (state_q == ST_IDLE);

  always_comb begin
    case (state_q)
      ST_RUN, ST_DRAIN: status = CODE_RUN;
      ST_HOLD:          status = CODE_PAUSE;
      default:          status = CODE_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      to_stop_q <= 1'b0;
      extra_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (run_cmd) state_q <= ST_RUN;
        ST_RUN: begin
          if (halt_cmd) begin
            state_q   <= ST_DRAIN;
            to_stop_q <= stop_cmd;
            extra_q   <= sync_in && !remain_zero;
          end else if (blk_end && !autoinit_en) begin
            state_q <= ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (launch)   extra_q   <= 1'b0;
          if (stop_cmd) to_stop_q <= 1'b1;
          if (drain_done) begin
            extra_q <= 1'b0;
            if ((blk_end && !autoinit_en) || to_stop_q || stop_cmd) state_q <= ST_IDLE;
            else                                                   state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (run_cmd)       state_q <= ST_RUN;
          else if (stop_cmd) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  assert_restart_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && run_cmd && !blk_end) |=> (state_q == ST_RUN));
  assert_pause_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == CODE_PAUSE) && ($past(status) == CODE_RUN)) |-> $past(quiet));
  assert_stop_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == CODE_STOP) && ($past(status) == CODE_RUN)) |-> $past(quiet));
endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int ELEM_BYTES = 4,
  parameter int MAX_PEND   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic [1:0]        status,
  input  logic              autoinit_en,
  input  logic              sync_in,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              rld_wr,
  input  logic [ADDR_W-1:0] rld_src,
  input  logic [ADDR_W-1:0] rld_dst,
  input  logic [CNT_W-1:0]  rld_cnt,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_cpl,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr
);
  logic rd_go, reload, idle, quiet, remain_zero, launch, rd_fire, wr_fire;

  dma_rc_fsm u_fsm (
    .clk, .rst_n, .cmd_valid, .cmd_code, .sync_in, .autoinit_en,
    .quiet, .remain_zero, .launch, .rd_go, .reload, .idle, .status
  );

  dma_rc_xfer #(.MAX_PEND(MAX_PEND)) u_xfer (
    .clk, .rst_n, .rd_go, .remain_zero, .rd_ready, .rd_cpl, .wr_ready,
    .launch, .rd_valid, .rd_fire, .wr_valid, .wr_fire, .quiet
  );

  dma_rc_params #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ELEM_BYTES(ELEM_BYTES)) u_params (
    .clk, .rst_n, .cfg_en(cfg_wr && idle), .cfg_src, .cfg_dst, .cfg_cnt,
    .rld_wr, .rld_src, .rld_dst, .rld_cnt, .reload, .launch, .rd_fire, .wr_fire,
    .rd_addr, .wr_addr, .remain_zero
  );

  // R12: working registers stay put while the channel is not stopped
  assert_cfg_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (status != 2'b00) && !rd_valid && !wr_valid) |=> $stable(rd_addr));
endmodule

// File: tb/dma_run_ctrl_bench.sv
module dma_run_ctrl_bench;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic [1:0] status;
  logic autoinit_en = 1'b0, sync_in = 1'b1;
  logic cfg_wr = 1'b0, rld_wr = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0, rld_src = '0, rld_dst = '0;
  logic [CW-1:0] cfg_cnt = '0, rld_cnt = '0;
  logic rd_valid, rd_ready = 1'b1, rd_cpl = 1'b0;
  logic wr_valid, wr_ready = 1'b1;
  logic [AW-1:0] rd_addr, wr_addr;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [AW-1:0] rd_log [0:63];
  logic [AW-1:0] wr_log [0:63];
  int rd_n = 0, wr_n = 0;
  int cpl_tmr = 0;

  always #4 clk = ~clk;

  dma_run_ctrl #(.ADDR_W(AW), .CNT_W(CW), .ELEM_BYTES(4), .MAX_PEND(2)) u_dma_run_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_code, .status, .autoinit_en, .sync_in,
    .cfg_wr, .cfg_src, .cfg_dst, .cfg_cnt, .rld_wr, .rld_src, .rld_dst, .rld_cnt,
    .rd_valid, .rd_ready, .rd_addr, .rd_cpl, .wr_valid, .wr_ready, .wr_addr
  );

  // memory model and transfer logger
  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin
      if (rd_n < 64) rd_log[rd_n] = rd_addr;
      rd_n = rd_n + 1;
      cpl_tmr <= LAT;
    end else if (cpl_tmr != 0) begin
      cpl_tmr <= cpl_tmr - 1;
    end
    rd_cpl <= (cpl_tmr == 1);
    if (wr_valid && wr_ready) begin
      if (wr_n < 64) wr_log[wr_n] = wr_addr;
      wr_n = wr_n + 1;
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] n);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_src = s; cfg_dst = d; cfg_cnt = n;
    @(negedge clk);
    cfg_wr = 1'b0;
    rd_n = 0; wr_n = 0;
  endtask

  task automatic wait_status(input logic [1:0] v);
    for (int i = 0; i < 400 && status != v; i++) @(negedge clk);
  endtask

  task automatic wait_reads(input int n);
    for (int i = 0; i < 400 && rd_n < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 status", status, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_valid", wr_valid, 0);
  endtask

  task automatic t_block;
    sync_in = 1; wr_ready = 1;
    setup(32'h100, 32'h200, 3);
    cmd(2'b01);
    chk("R2 status run", status, 1);
    wait_status(2'b00);
    chk("R7 reads", rd_n, 3);
    chk("R7 writes", wr_n, 3);
    chk("R2 rd addr 2", rd_log[2], 32'h108);
    chk("R2 wr addr 0", wr_log[0], 32'h200);
    chk("R2 wr addr 2", wr_log[2], 32'h208);
  endtask

  task automatic t_backpressure;
    wr_ready = 0;
    setup(32'h300, 32'h400, 5);
    cmd(2'b01);
    repeat (30) @(negedge clk);
    chk("R11 reads capped", rd_n, 2);
    chk("R11 wr_valid held", wr_valid, 1);
    chk("R11 no writes", wr_n, 0);
    wr_ready = 1;
    wait_status(2'b00);
    chk("R11 writes done", wr_n, 5);
  endtask

  task automatic t_restart;
    wr_ready = 0;
    setup(32'h500, 32'h600, 6);
    cmd(2'b01);
    wait_reads(2);
    cmd(2'b01);
    chk("R3 still running", status, 1);
    wr_ready = 1;
    wait_status(2'b00);
    chk("R3 reads", rd_n, 6);
    chk("R3 writes", wr_n, 6);
    chk("R3 rd addr 5", rd_log[5], 32'h514);
    chk("R3 wr addr 5", wr_log[5], 32'h614);
  endtask

  task automatic t_pause_nosync;
    wr_ready = 0; sync_in = 1;
    setup(32'h700, 32'h800, 8);
    cmd(2'b01);
    wait_reads(2);
    sync_in = 0;
    cmd(2'b10);
    repeat (10) @(negedge clk);
    chk("R4 not yet paused", status, 1);
    wr_ready = 1;
    wait_status(2'b10);
    chk("R4 paused", status, 2'b10);
    chk("R4 reads", rd_n, 2);
    chk("R4 writes", wr_n, 2);
    cmd(2'b00);
    chk("R6 stop from paused", status, 0);
    sync_in = 1;
  endtask

  task automatic t_pause_extra;
    wr_ready = 0; sync_in = 1;
    setup(32'h900, 32'hA00, 8);
    cmd(2'b01);
    wait_reads(2);
    cmd(2'b10);
    wr_ready = 1;
    wait_status(2'b10);
    chk("R5 extra read", rd_n, 3);
    chk("R5 extra write", wr_n, 3);
    cmd(2'b01);
    chk("R6 resume", status, 1);
    wait_status(2'b00);
    chk("R6 resume reads", rd_n, 8);
    chk("R6 resume addr", rd_log[7], 32'h91C);
  endtask

  task automatic t_stop_drain;
    wr_ready = 0; sync_in = 1;
    setup(32'hB00, 32'hC00, 8);
    cmd(2'b01);
    wait_reads(2);
    sync_in = 0;
    cmd(2'b00);
    repeat (5) @(negedge clk);
    chk("R6 draining", status, 1);
    wr_ready = 1;
    wait_status(2'b00);
    chk("R6 stopped writes", wr_n, 2);
    sync_in = 1;
  endtask

  task automatic t_autoinit;
    wr_ready = 1; sync_in = 1; autoinit_en = 1;
    setup(32'h1000, 32'h2000, 2);
    cmd(2'b01);
    rld_wr = 1; rld_src = 32'h3000; rld_dst = 32'h4000; rld_cnt = 3;
    @(negedge clk);
    rld_wr = 0;
    for (int i = 0; i < 400 && wr_n < 5; i++) @(negedge clk);
    chk("R8 still running", status, 1);
    chk("R9 first block rd", rd_log[1], 32'h1004);
    chk("R9 first block wr", wr_log[1], 32'h2004);
    chk("R8 reload rd", rd_log[2], 32'h3000);
    chk("R8 reload rd end", rd_log[4], 32'h3008);
    chk("R8 reload wr", wr_log[4], 32'h4008);
    sync_in = 0;
    cmd(2'b00);
    wait_status(2'b00);
    chk("R6 stop after reload", status, 0);
    autoinit_en = 0; sync_in = 1;
  endtask

  task automatic t_code11_cfg;
    wr_ready = 0; sync_in = 1;
    setup(32'h5000, 32'h6000, 4);
    cmd(2'b01);
    cmd(2'b11);
    chk("R10 run ignores 11", status, 1);
    @(negedge clk);
    cfg_wr = 1; cfg_src = 32'h9000;
    @(negedge clk);
    cfg_wr = 0;
    wr_ready = 1;
    wait_status(2'b00);
    chk("R12 locked while running", rd_log[3], 32'h500C);
    cmd(2'b11);
    repeat (10) @(negedge clk);
    chk("R10 stopped ignores 11", status, 0);
    chk("R10 no read after 11", rd_n, 4);
    setup(32'h7000, 32'h7800, 1);
    cmd(2'b01);
    wait_status(2'b00);
    chk("R12 stopped write applies", rd_log[0], 32'h7000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_block();
    t_backpressure();
    t_restart();
    t_pause_nosync();
    t_pause_extra();
    t_stop_drain();
    t_autoinit();
    t_code11_cfg();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule